// File: doc/BRIEF.md
# Hexadecimal Floating Point Adder

This block adds or subtracts two numbers held in a base-16 floating point format. A word has a sign in bit 31, a 7-bit exponent in bits 30:24 (excess 64, a power of sixteen) and a 24-bit fraction in bits 23:0, read as six hex digits after the radix point. In double precision a second 32-bit word carries eight more fraction digits, for fourteen in all. Inputs may be unnormalized. The block normalizes them, orders them by magnitude, aligns the smaller one by whole hex digits, adds or subtracts, renormalizes, rounds where the mode asks for it, and packs the result with a condition code.

The operation is sequential. A one-cycle `start_i` while the unit is idle captures the operands and the three control bits. The packed result and condition code appear together with a one-cycle `done_o` five clock cycles later. Single precision has two variants. The rounding variant aligns over the full fourteen digits and rounds on the first discarded bit. The truncating variant aligns only the six-digit high fraction. Double precision always aligns over fourteen digits and is never rounded.

Top module: `hfp_adder`

## Requirements
- R1: A normal result is packed as sign in bit 31, exponent in bits 30:24 and fraction in bits 23:0. In single precision (`dbl_i`=0) both low input words are ignored and `res_lo_o` is zero.
- R2: Before any arithmetic, a nonzero operand is shifted left one hex digit at a time, with its exponent decremented per digit, until its leading digit is nonzero. A zero fraction becomes +0 with exponent 0.
- R3: With `sub_i`=1 the sign of operand B is inverted before any other processing.
- R4: If one operand is zero the result is the other operand. If both are zero the result is 0 with condition code 0.
- R5: The operand of larger magnitude sets the result sign. Magnitude is ordered by exponent, then high fraction, then low fraction.
- R6: The smaller fraction is shifted right by 4 bits per unit of exponent difference. In double precision, or in single precision with `rnd_i`=1, the full 56-bit fraction is shifted, and a difference of 14 or more clears it. In single precision with `rnd_i`=0 only the 24-bit high fraction is shifted, bits shifted out are lost, and a difference of 6 or more clears it.
- R7: For like effective signs the fractions are added. A carry out of the 56-bit fraction shifts it right by one digit and increments the exponent.
- R8: For unlike effective signs the smaller fraction is subtracted from the larger and the result is renormalized. Exact cancellation gives +0 with condition code 0.
- R9: Single precision with `rnd_i`=1 adds one to the high fraction when bit 31 of the low fraction is set. A carry from that add shifts the fraction right one digit and increments the exponent. Double precision is truncated.
- R10: An exponent above 127 gives `res_hi_o`=0x7FFFFFFF (positive) or 0xFFFFFFFF (negative) and `res_lo_o`=0xFFFFFFFF. The condition code is V with G, or V with L.
- R11: A nonzero result whose exponent is below 0 gives `res_hi_o`=`res_lo_o`=0 and condition code V only.
- R12: The condition code is {C,V,G,L} in bits 3..0. A normal result gives G (4'h2) when positive and L (4'h1) when negative. C is never set.
- R13: `done_o` is high for exactly one cycle, five clock cycles after the edge that accepted `start_i`, and the result outputs change only on that edge. A `start_i` while an operation is in progress is ignored. After reset `done_o`, the result words and the condition code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted when idle) |
| sub_i | input | 1 | 1 = subtract B from A |
| dbl_i | input | 1 | 1 = double precision |
| rnd_i | input | 1 | Single precision: 1 = full alignment and rounding, 0 = six-digit truncation |
| a_hi_i | input | 32 | Operand A sign, exponent, high fraction |
| a_lo_i | input | 32 | Operand A low fraction |
| b_hi_i | input | 32 | Operand B sign, exponent, high fraction |
| b_lo_i | input | 32 | Operand B low fraction |
| res_hi_o | output | 32 | Result sign, exponent, high fraction |
| res_lo_o | output | 32 | Result low fraction |
| cc_o | output | 4 | Condition code {C,V,G,L} |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench runs an unnormalized operand that would shift the sum by two digits if pre-normalization were skipped. It runs alignment differences on both sides of the 6-digit and 14-digit cut-offs, where a wrong limit keeps or loses a trailing 1. One sum is added in both single modes to show that truncation drops the digit shifted out and rounding recovers it. A rounding carry out of 0xFFFFFF must bump the exponent, and an adder that misses it wraps the fraction to zero. The bench also runs overflow and underflow of both signs and exact cancellation, so a wrong fill pattern or a missing V flag shows up. Finally it issues a second start while the unit is busy, which a design that restarts would answer with the wrong sum.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
    parameter int EXP_W = 7;
    parameter int HI_W  = 24;
    parameter int LO_W  = 32;

    localparam int WORD_W    = 1 + EXP_W + HI_W;
    localparam int FRAC_W    = HI_W + LO_W;
    localparam int DIGITS    = FRAC_W / 4;
    localparam int SP_DIGITS = HI_W / 4;
    localparam int XW        = EXP_W + 2;
    localparam int EXP_MAX   = (1 << EXP_W) - 1;
    localparam int LZ_W      = $clog2(DIGITS + 1);

    localparam logic [3:0] CC_C = 4'b1000;
    localparam logic [3:0] CC_V = 4'b0100;
    localparam logic [3:0] CC_G = 4'b0010;
    localparam logic [3:0] CC_L = 4'b0001;

    // unpacked operand; exp is two's complement, may go below zero
    typedef struct packed {
        logic              sign;
        logic [XW-1:0]     exp;
        logic [FRAC_W-1:0] frac;
    } hfp_val_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ALGN = 3'd1,
        ST_ARIT = 3'd2,
        ST_NORM = 3'd3,
        ST_PACK = 3'd4
    } hfp_state_t;

    typedef struct packed {
        hfp_state_t        st;
        logic              dbl;
        logic              rnd;
        hfp_val_t          opa;
        hfp_val_t          opb;
        hfp_val_t          acc;
        logic [WORD_W-1:0] hi;
        logic [LO_W-1:0]   lo;
        logic [3:0]        cc;
        logic              done;
    } hfp_regs_t;
endpackage

// File: rtl/hfp_norm.sv
module hfp_norm
    import hfp_pkg::*;
(
    input  hfp_val_t val_i,
    output hfp_val_t val_o
);
    logic [LZ_W-1:0] lz;
    logic            found;

    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            if (!found && val_i.frac[i*4 +: 4] == 4'h0) lz = lz + LZ_W'(1);
            else found = 1'b1;
        end
        if (!found) begin
            val_o = '0;                       // clean zero
        end else begin
            val_o.sign = val_i.sign;
            val_o.exp  = val_i.exp - XW'(lz);
            val_o.frac = val_i.frac << {lz, 2'b00};
        end
    end
endmodule

// File: rtl/hfp_align.sv
module hfp_align
    import hfp_pkg::*;
(
    input  hfp_val_t a_i,
    input  hfp_val_t b_i,
    input  logic     trunc_sp_i,
    output hfp_val_t big_o,
    output hfp_val_t small_o
);
    logic          a_zero;
    logic          b_zero;
    logic          a_less;
    logic [XW-1:0] ediff;
    hfp_val_t      big;
    hfp_val_t      sml;

    always_comb begin
        a_zero = (a_i.frac == '0);
        b_zero = (b_i.frac == '0);
        a_less = ($signed(a_i.exp) < $signed(b_i.exp)) ||
                 ((a_i.exp == b_i.exp) && (a_i.frac < b_i.frac));
        if (a_less) begin
            big = b_i;
            sml = a_i;
        end else begin
            big = a_i;
            sml = b_i;
        end
        ediff   = big.exp - sml.exp;
        small_o = sml;
        if (a_zero || b_zero) begin
            big_o        = a_zero ? b_i : a_i;
            small_o      = '0;
            small_o.sign = big_o.sign;
        end else begin
            big_o = big;
            if (trunc_sp_i) begin
                if (ediff >= XW'(SP_DIGITS))
                    small_o.frac[FRAC_W-1:LO_W] = '0;
                else
                    small_o.frac[FRAC_W-1:LO_W] = sml.frac[FRAC_W-1:LO_W] >> {ediff, 2'b00};
            end else begin
                if (ediff >= XW'(DIGITS))
                    small_o.frac = '0;
                else
                    small_o.frac = sml.frac >> {ediff, 2'b00};
            end
        end
    end
endmodule

// File: rtl/hfp_pack.sv
module hfp_pack
    import hfp_pkg::*;
(
    input  hfp_val_t          acc_i,
    input  logic              dbl_i,
    input  logic              rnd_i,
    output logic [WORD_W-1:0] hi_o,
    output logic [LO_W-1:0]   lo_o,
    output logic [3:0]        cc_o
);
    logic [HI_W-1:0] frac_hi;
    logic [LO_W-1:0] frac_lo;
    logic [HI_W:0]   bump;
    logic [XW-1:0]   ex;
    logic            is_zero;
    logic            udf;
    logic            ovf;

    always_comb begin
        frac_hi = acc_i.frac[FRAC_W-1 -: HI_W];
        frac_lo = acc_i.frac[LO_W-1:0];
        ex      = acc_i.exp;
        bump    = {1'b0, frac_hi} + (HI_W + 1)'(1);
        if (!dbl_i && rnd_i && frac_lo[LO_W-1]) begin
            if (bump[HI_W]) begin
                frac_hi = {3'b000, bump[HI_W:4]};
                ex      = ex + XW'(1);
            end else begin
                frac_hi = bump[HI_W-1:0];
            end
        end
        is_zero = (frac_hi == '0);
        udf     = ex[XW-1];
        ovf     = !ex[XW-1] && (ex > XW'(EXP_MAX));
        hi_o    = '0;
        lo_o    = '0;
        cc_o    = '0;
        if (!is_zero) begin
            if (udf) begin
                cc_o = CC_V;
            end else if (ovf) begin
                hi_o = {acc_i.sign, {(WORD_W - 1){1'b1}}};
                lo_o = '1;
                cc_o = CC_V | (acc_i.sign ? CC_L : CC_G);
            end else begin
                hi_o = {acc_i.sign, ex[EXP_W-1:0], frac_hi};
                lo_o = dbl_i ? frac_lo : '0;
                cc_o = acc_i.sign ? CC_L : CC_G;
            end
        end
    end
endmodule

// File: rtl/hfp_adder.sv
module hfp_adder
    import hfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sub_i,
    input  logic              dbl_i,
    input  logic              rnd_i,
    input  logic [WORD_W-1:0] a_hi_i,
    input  logic [LO_W-1:0]   a_lo_i,
    input  logic [WORD_W-1:0] b_hi_i,
    input  logic [LO_W-1:0]   b_lo_i,
    output logic [WORD_W-1:0] res_hi_o,
    output logic [LO_W-1:0]   res_lo_o,
    output logic [3:0]        cc_o,
    output logic              done_o
);
    hfp_regs_t r_d, r_q;

    hfp_val_t          raw [2];
    hfp_val_t          nrm [2];
    hfp_val_t          big, sml, acc_n;
    logic [FRAC_W:0]   sum;
    logic [WORD_W-1:0] pk_hi;
    logic [LO_W-1:0]   pk_lo;
    logic [3:0]        pk_cc;
    logic              accept;

    // raw operands: sign flip for subtract before anything else (R3)
    always_comb begin
        raw[0].sign = a_hi_i[WORD_W-1];
        raw[0].exp  = {2'b00, a_hi_i[WORD_W-2 -: EXP_W]};
        raw[0].frac = {a_hi_i[HI_W-1:0], dbl_i ? a_lo_i : '0};
        raw[1].sign = b_hi_i[WORD_W-1] ^ sub_i;
        raw[1].exp  = {2'b00, b_hi_i[WORD_W-2 -: EXP_W]};
        raw[1].frac = {b_hi_i[HI_W-1:0], dbl_i ? b_lo_i : '0};
    end

    for (genvar g = 0; g < 2; g++) begin : g_in_norm
        hfp_norm u_norm (.val_i(raw[g]), .val_o(nrm[g]));
    end

    hfp_align u_align (
        .a_i        (r_q.opa),
        .b_i        (r_q.opb),
        .trunc_sp_i (!r_q.dbl && !r_q.rnd),
        .big_o      (big),
        .small_o    (sml)
    );

    hfp_norm u_res_norm (.val_i(r_q.acc), .val_o(acc_n));

    hfp_pack u_pack (
        .acc_i (r_q.acc),
        .dbl_i (r_q.dbl),
        .rnd_i (r_q.rnd),
        .hi_o  (pk_hi),
        .lo_o  (pk_lo),
        .cc_o  (pk_cc)
    );

    assign accept = start_i && (r_q.st == ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.opa.sign ^ r_q.opb.sign)
            sum = {1'b0, r_q.opa.frac} - {1'b0, r_q.opb.frac};
        else
            sum = {1'b0, r_q.opa.frac} + {1'b0, r_q.opb.frac};
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.opa = nrm[0];
                    r_d.opb = nrm[1];
                    r_d.dbl = dbl_i;
                    r_d.rnd = rnd_i;
                    r_d.st  = ST_ALGN;
                end
            end
            ST_ALGN: begin
                r_d.opa = big;
                r_d.opb = sml;
                r_d.st  = ST_ARIT;
            end
            ST_ARIT: begin
                r_d.acc.sign = r_q.opa.sign;
                r_d.acc.exp  = r_q.opa.exp;
                if (!(r_q.opa.sign ^ r_q.opb.sign) && sum[FRAC_W]) begin
                    r_d.acc.frac = {3'b000, sum[FRAC_W:4]};
                    r_d.acc.exp  = r_q.opa.exp + XW'(1);
                end else begin
                    r_d.acc.frac = sum[FRAC_W-1:0];
                end
                r_d.st = ST_NORM;
            end
            ST_NORM: begin
                r_d.acc = acc_n;
                r_d.st  = ST_PACK;
            end
            ST_PACK: begin
                r_d.hi   = pk_hi;
                r_d.lo   = pk_lo;
                r_d.cc   = pk_cc;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign res_hi_o = r_q.hi;
    assign res_lo_o = r_q.lo;
    assign cc_o     = r_q.cc;
    assign done_o   = r_q.done;

    // R13: fixed latency from an accepted start
    p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(accept, 5));
    // R13: single-cycle done
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10: saturated fill on overflow
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cc_o[2] && (cc_o[1] || cc_o[0])) |->
        (res_hi_o[WORD_W-2:0] == '1 && res_lo_o == '1));
    // R11: underflow leaves a clean zero
    p_underflow_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cc_o == CC_V) |-> (res_hi_o == '0 && res_lo_o == '0));
    // R12: G and L exclusive
    p_gl_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(cc_o[1] && cc_o[0]));
    // R8: result reaching pack is normalized or clean zero
    p_result_norm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PACK) |->
        (r_q.acc.frac == '0 || r_q.acc.frac[FRAC_W-1 -: 4] != 4'h0));
endmodule

// File: tb/hfp_adder_bench.sv
module hfp_adder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, sub_i = 1'b0, dbl_i = 1'b0, rnd_i = 1'b0;
    logic [31:0] a_hi_i = '0, a_lo_i = '0, b_hi_i = '0, b_lo_i = '0;
    logic [31:0] res_hi_o, res_lo_o;
    logic [3:0]  cc_o;
    logic        done_o;
    int          total = 0;
    int          bad = 0;
    int          cyc;

    always #2 clk = ~clk;

    hfp_adder u_hfp_adder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .dbl_i(dbl_i), .rnd_i(rnd_i), .a_hi_i(a_hi_i), .a_lo_i(a_lo_i),
        .b_hi_i(b_hi_i), .b_lo_i(b_lo_i), .res_hi_o(res_hi_o),
        .res_lo_o(res_lo_o), .cc_o(cc_o), .done_o(done_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [31:0] ahi, alo, bhi, blo;
        logic        sub, dbl, rnd;
        logic [31:0] ehi, elo;
        logic [3:0]  ecc;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t TBL [NV] = '{
        '{8'd1,  32'h41100000, 32'h0, 32'h41200000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h41300000, 32'h0, 4'h2}, // R1
        '{8'd1,  32'h41100000, 32'hFFFFFFFF, 32'h41100000, 32'hAAAAAAAA, 1'b0, 1'b0, 1'b1, 32'h41200000, 32'h0, 4'h2}, // R1
        '{8'd2,  32'h43001000, 32'h0, 32'h41100000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h41200000, 32'h0, 4'h2}, // R2
        '{8'd3,  32'h41100000, 32'h0, 32'h41300000, 32'h0, 1'b1, 1'b0, 1'b1, 32'hC1200000, 32'h0, 4'h1}, // R3
        '{8'd3,  32'hC1300000, 32'h0, 32'hC1100000, 32'h0, 1'b1, 1'b0, 1'b1, 32'hC1200000, 32'h0, 4'h1}, // R3
        '{8'd4,  32'h00000000, 32'h0, 32'hC1500000, 32'h0, 1'b0, 1'b0, 1'b1, 32'hC1500000, 32'h0, 4'h1}, // R4
        '{8'd4,  32'h41500000, 32'h0, 32'h80000000, 32'h0, 1'b1, 1'b0, 1'b1, 32'h41500000, 32'h0, 4'h2}, // R4
        '{8'd4,  32'h00000000, 32'h0, 32'h41100000, 32'h12345678, 1'b0, 1'b1, 1'b0, 32'h41100000, 32'h12345678, 4'h2}, // R4
        '{8'd4,  32'h00000000, 32'h0, 32'h00000000, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 4'h0}, // R4
        '{8'd5,  32'h41100000, 32'h0, 32'hC2100000, 32'h0, 1'b0, 1'b0, 1'b1, 32'hC1F00000, 32'h0, 4'h1}, // R5
        '{8'd6,  32'h41100000, 32'h0, 32'h3B100000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h41100000, 32'h0, 4'h2}, // R6
        '{8'd6,  32'h41100000, 32'h0, 32'h3C100000, 32'h0, 1'b0, 1'b0, 1'b0, 32'h41100001, 32'h0, 4'h2}, // R6
        '{8'd6,  32'h41100000, 32'h0, 32'h40FFFFFF, 32'h0, 1'b0, 1'b0, 1'b0, 32'h411FFFFF, 32'h0, 4'h2}, // R6
        '{8'd6,  32'h41100000, 32'h0, 32'h33100000, 32'h0, 1'b0, 1'b1, 1'b0, 32'h41100000, 32'h0, 4'h2}, // R6
        '{8'd6,  32'h41100000, 32'h0, 32'h34100000, 32'h0, 1'b0, 1'b1, 1'b0, 32'h41100000, 32'h1, 4'h2}, // R6
        '{8'd7,  32'h41800000, 32'h0, 32'h41800000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h42100000, 32'h0, 4'h2}, // R7
        '{8'd8,  32'h41300000, 32'h0, 32'h41300000, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 4'h0}, // R8
        '{8'd8,  32'h42100000, 32'h0, 32'h41F00000, 32'h0, 1'b1, 1'b0, 1'b1, 32'h41100000, 32'h0, 4'h2}, // R8
        '{8'd8,  32'h41100000, 32'h1, 32'h41100000, 32'h0, 1'b1, 1'b1, 1'b0, 32'h34100000, 32'h0, 4'h2}, // R8
        '{8'd9,  32'h41100000, 32'h0, 32'h40FFFFFF, 32'h0, 1'b0, 1'b0, 1'b1, 32'h41200000, 32'h0, 4'h2}, // R9
        '{8'd9,  32'h41FFFFFF, 32'h0, 32'h3B800000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h42100000, 32'h0, 4'h2}, // R9
        '{8'd9,  32'h41FFFFFF, 32'h0, 32'h3B800000, 32'h0, 1'b0, 1'b1, 1'b0, 32'h41FFFFFF, 32'h80000000, 4'h2}, // R9
        '{8'd10, 32'h7FF00000, 32'h0, 32'h7FF00000, 32'h0, 1'b0, 1'b0, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 4'h6}, // R10
        '{8'd10, 32'hFFF00000, 32'h0, 32'hFFF00000, 32'h0, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'h5}, // R10
        '{8'd11, 32'h00110000, 32'h0, 32'h00100000, 32'h0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 4'h4}  // R11
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive one operation and wait for done; cyc counts negedges to done
    task automatic run_op(input logic [31:0] ahi, alo, bhi, blo,
                          input logic sub, dbl, rnd);
        @(negedge clk);
        a_hi_i = ahi; a_lo_i = alo; b_hi_i = bhi; b_lo_i = blo;
        sub_i = sub; dbl_i = dbl; rnd_i = rnd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R13 watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13", "reset done", {31'h0, done_o}, 32'h0);
        check("R13", "reset hi", res_hi_o, 32'h0);
        check("R13", "reset cc", {28'h0, cc_o}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", TBL[i].req);
            run_op(TBL[i].ahi, TBL[i].alo, TBL[i].bhi, TBL[i].blo,
                   TBL[i].sub, TBL[i].dbl, TBL[i].rnd);
            check(tag, $sformatf("vec%0d hi", i), res_hi_o, TBL[i].ehi);
            check(tag, $sformatf("vec%0d lo", i), res_lo_o, TBL[i].elo);
            check(tag, $sformatf("vec%0d cc", i), {28'h0, cc_o}, {28'h0, TBL[i].ecc});
            // R12: C bit never set
            check("R12", $sformatf("vec%0d C bit", i), {31'h0, cc_o[3]}, 32'h0);
        end

        // R13: latency and single-cycle pulse
        run_op(32'h41100000, 32'h0, 32'h41200000, 32'h0, 1'b0, 1'b0, 1'b1);
        check("R13", "latency", cyc, 32'd5);
        @(negedge clk);
        check("R13", "done width", {31'h0, done_o}, 32'h0);

        // R13: start while busy is ignored
        @(negedge clk);
        a_hi_i = 32'h41100000; b_hi_i = 32'h41200000; a_lo_i = '0; b_lo_i = '0;
        sub_i = 1'b0; dbl_i = 1'b0; rnd_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        a_hi_i = 32'h7FF00000; b_hi_i = 32'h7FF00000;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 2;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        check("R13", "busy start latency", cyc, 32'd5);
        check("R13", "busy start result", res_hi_o, 32'h41300000);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R13", "no second done", extra, 32'd0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule